// File: doc/BRIEF.md
# Channel Event Status Collector with Interrupt Overflow

This block gathers event status for a bank of timer channels. Every channel has two kinds of event: interrupt requests and data transfer requests. A one-cycle hardware pulse from a channel engine sets a pending bit for that event kind. When a channel raises a new interrupt while its earlier interrupt is still pending, a separate overflow bit for that channel is set. The overflow bit stays set until the host clears it.

A host reaches the block through a small word-addressed register port. Each write lasts one cycle, and read data comes back one cycle after the address. The host can look at the bits in two ways:

- as grouped words, one per bit kind, with one bit for each channel;
- as a per-channel word that holds all three bits of one channel.

Both views use the same storage, and a bit can be cleared from either view by writing 1 to it. The per-channel bits are also driven out on ports. A level interrupt output tells an interrupt controller that some channel has a pending interrupt.

Top module: `chan_evt_status`

## Requirements
- R1: After reset, every interrupt status, overflow and transfer status bit is 0. `irq_any_o` is 0 and `reg_rdata_o` is 0.
- R2: A pulse on `irq_evt_i[n]` sets the interrupt status of channel n on the next clock edge. The grouped interrupt word at word offset 0 shows channel n at data bit n, where bit 31 is the MSB.
- R3: A pulse on `irq_evt_i[n]` while channel n's interrupt status is already 1 sets that channel's overflow bit. The overflow bit is read at offset 1, with channel n at bit n.
- R4: The first interrupt on a channel whose status is 0 does not set overflow. Clearing the interrupt status leaves the overflow bit set, and overflow stays 1 until it is itself cleared.
- R5: Writing to offsets 0, 1 or 2 clears each bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R6: A pulse on `xfer_evt_i[n]` sets channel n's transfer request status. This status reads at offset 2, bit n, and is cleared by writing 1.
- R7: If a hardware set and a host write-1 clear reach the same bit in the same cycle, the bit ends up 1.
- R8: Offset 32+n is channel n's own view: bit 0 is interrupt status, bit 1 is overflow, bit 2 is transfer status. This view uses the same storage as the grouped words, so writing 1 to these bits clears the matching grouped bits. The same bits drive `ch_irq_o`, `ch_ovf_o` and `ch_xfer_o`.
- R9: `reg_rdata_o` shows the word at the address presented one clock edge earlier. Unmapped offsets read 0.
- R10: Writes to the read-only offset 3, or to any unmapped offset, change no state.
- R11: `irq_any_o` is 1 exactly when at least one interrupt status bit is 1.
- R12: Offset 3 is a read-only summary: bit 0 is any interrupt pending, bit 1 is any overflow, bit 2 is any transfer pending. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_evt_i | input | NUM_CH | Per-channel interrupt event pulses |
| xfer_evt_i | input | NUM_CH | Per-channel data transfer request pulses |
| reg_addr_i | input | 6 | Register word address |
| reg_wr_i | input | 1 | Single-cycle write strobe |
| reg_wdata_i | input | 32 | Write data (1 clears) |
| reg_rdata_o | output | 32 | Registered read data |
| irq_any_o | output | 1 | Level interrupt, any status pending |
| ch_irq_o | output | NUM_CH | Per-channel interrupt status |
| ch_ovf_o | output | NUM_CH | Per-channel interrupt overflow |
| ch_xfer_o | output | NUM_CH | Per-channel transfer request status |

## Verification
The bench builds the block with NUM_CH set to 8, which leaves the upper per-channel offsets unmapped inside the 6-bit address space. The bench walks every channel through four cases:

- set, overflow and clear;
- a clear attempt with 0 data;
- a set and a clear in the same cycle;
- clears through the per-channel view.

A long pseudo-random run then mixes event pulses with writes to every mapped, read-only and unmapped offset. After each step it compares the ports and one read-back against an arithmetic model.

// File: rtl/chan_evt_pkg.sv
package chan_evt_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 6;
    localparam int OFS_IRQ     = 0;
    localparam int OFS_OVF     = 1;
    localparam int OFS_XFER    = 2;
    localparam int OFS_SUM     = 3;
    localparam int OFS_CH_BASE = 32;

    // bit 0 irq, bit 1 overflow, bit 2 transfer
    typedef struct packed {
        logic xfer;
        logic ovf;
        logic irq;
    } ch_bits_t;

    typedef enum logic [2:0] {
        SEL_IRQ,
        SEL_OVF,
        SEL_XFER,
        SEL_SUM,
        SEL_CHAN,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] addr, input int num_ch);
        int a;
        a = int'(addr);
        if (a == OFS_IRQ)       return SEL_IRQ;
        else if (a == OFS_OVF)  return SEL_OVF;
        else if (a == OFS_XFER) return SEL_XFER;
        else if (a == OFS_SUM)  return SEL_SUM;
        else if (a >= OFS_CH_BASE && a < OFS_CH_BASE + num_ch) return SEL_CHAN;
        else                    return SEL_NONE;
    endfunction

endpackage

// File: rtl/chan_evt_cell.sv
module chan_evt_cell
    import chan_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     irq_set_i,
    input  logic     xfer_set_i,
    input  ch_bits_t clr_i,
    output ch_bits_t stat_o
);

    ch_bits_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.ovf  <= (irq_set_i & stat_q.irq) | (stat_q.ovf & ~clr_i.ovf);
            stat_q.irq  <= irq_set_i  | (stat_q.irq  & ~clr_i.irq);
            stat_q.xfer <= xfer_set_i | (stat_q.xfer & ~clr_i.xfer);
        end
    end

    assign stat_o = stat_q;

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        irq_set_i |=> stat_q.irq); // R7
    AST_OVF_DETECT: assert property (@(posedge clk) disable iff (rst)
        (irq_set_i && stat_q.irq) |=> stat_q.ovf); // R3
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat_q.ovf && !clr_i.ovf) |=> stat_q.ovf); // R4
    AST_NO_SPURIOUS_OVF: assert property (@(posedge clk) disable iff (rst)
        (!stat_q.ovf && !(irq_set_i && stat_q.irq)) |=> !stat_q.ovf); // R4
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_i.irq && !irq_set_i) |=> !stat_q.irq); // R5
    AST_XFER_SET: assert property (@(posedge clk) disable iff (rst)
        xfer_set_i |=> stat_q.xfer); // R6

endmodule

// File: rtl/chan_evt_regif.sv
module chan_evt_regif
    import chan_evt_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  ch_bits_t [NUM_CH-1:0] stat_i,
    output ch_bits_t [NUM_CH-1:0] clr_o,
    output logic [DATA_W-1:0]     rdata_o
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_sel_e           sel;
    logic [IDX_W-1:0]   ch_idx;
    logic [DATA_W-1:0]  irq_word, ovf_word, xfer_word, sum_word;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;
    logic               unused_wdata;

    assign sel          = decode_addr(addr_i, NUM_CH);
    assign ch_idx       = addr_i[IDX_W-1:0];
    assign unused_wdata = ^wdata_i;

    generate
        for (genvar n = 0; n < DATA_W; n++) begin : g_word
            if (n < NUM_CH) begin : g_live
                assign irq_word[n]  = stat_i[n].irq;
                assign ovf_word[n]  = stat_i[n].ovf;
                assign xfer_word[n] = stat_i[n].xfer;
            end else begin : g_pad
                assign irq_word[n]  = 1'b0;
                assign ovf_word[n]  = 1'b0;
                assign xfer_word[n] = 1'b0;
            end
        end

        for (genvar n = 0; n < NUM_CH; n++) begin : g_clr
            logic own_hit;
            assign own_hit = wr_i && (sel == SEL_CHAN) && (ch_idx == IDX_W'(n));
            assign clr_o[n].irq  = (wr_i && sel == SEL_IRQ  && wdata_i[n]) || (own_hit && wdata_i[0]);
            assign clr_o[n].ovf  = (wr_i && sel == SEL_OVF  && wdata_i[n]) || (own_hit && wdata_i[1]);
            assign clr_o[n].xfer = (wr_i && sel == SEL_XFER && wdata_i[n]) || (own_hit && wdata_i[2]);
        end
    endgenerate

    assign sum_word = {{(DATA_W-3){1'b0}}, |xfer_word, |ovf_word, |irq_word};

    always_comb begin
        case (sel)
            SEL_IRQ:  rd_mux = irq_word;
            SEL_OVF:  rd_mux = ovf_word;
            SEL_XFER: rd_mux = xfer_word;
            SEL_SUM:  rd_mux = sum_word;
            SEL_CHAN: rd_mux = {{(DATA_W-3){1'b0}}, stat_i[ch_idx]};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;

    AST_NO_CLEAR_ON_RO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_SUM || sel == SEL_NONE || !wr_i) |-> (clr_o == '0)); // R10
    AST_SUM_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(sel == SEL_SUM) |-> (rdata_q[DATA_W-1:3] == '0)); // R12

endmodule

// File: rtl/chan_evt_status.sv
module chan_evt_status
    import chan_evt_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] irq_evt_i,
    input  logic [NUM_CH-1:0] xfer_evt_i,
    input  logic [5:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_any_o,
    output logic [NUM_CH-1:0] ch_irq_o,
    output logic [NUM_CH-1:0] ch_ovf_o,
    output logic [NUM_CH-1:0] ch_xfer_o
);

    ch_bits_t [NUM_CH-1:0] stat;
    ch_bits_t [NUM_CH-1:0] clr;

    initial begin
        if (NUM_CH < 1 || NUM_CH > DATA_W)
            $error("NUM_CH out of range");
    end

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            chan_evt_cell cell_i (
                .clk        (clk),
                .rst        (rst),
                .irq_set_i  (irq_evt_i[n]),
                .xfer_set_i (xfer_evt_i[n]),
                .clr_i      (clr[n]),
                .stat_o     (stat[n])
            );
            assign ch_irq_o[n]  = stat[n].irq;
            assign ch_ovf_o[n]  = stat[n].ovf;
            assign ch_xfer_o[n] = stat[n].xfer;
        end
    endgenerate

    chan_evt_regif #(.NUM_CH(NUM_CH)) regif_i (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .stat_i  (stat),
        .clr_o   (clr),
        .rdata_o (reg_rdata_o)
    );

    assign irq_any_o = |ch_irq_o;

    AST_IRQ_LEVEL_RISE: assert property (@(posedge clk) disable iff (rst)
        (|irq_evt_i) |=> irq_any_o); // R11

endmodule

// File: tb/chan_evt_status_tb_top.sv
module chan_evt_status_tb_top;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] irq_evt = '0;
    logic [NCH-1:0] xfer_evt = '0;
    logic [5:0]     addr = '0;
    logic           wr = 1'b0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic           irq_any;
    logic [NCH-1:0] ch_irq, ch_ovf, ch_xfer;

    logic [NCH-1:0] m_irq = '0, m_ovf = '0, m_xfer = '0;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    chan_evt_status #(.NUM_CH(NCH)) dut_i (
        .clk (clk), .rst (rst),
        .irq_evt_i (irq_evt), .xfer_evt_i (xfer_evt),
        .reg_addr_i (addr), .reg_wr_i (wr), .reg_wdata_i (wdata),
        .reg_rdata_o (rdata), .irq_any_o (irq_any),
        .ch_irq_o (ch_irq), .ch_ovf_o (ch_ovf), .ch_xfer_o (ch_xfer)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int a);
        logic [31:0] v;
        v = '0;
        if (a == 0)      v[NCH-1:0] = m_irq;
        else if (a == 1) v[NCH-1:0] = m_ovf;
        else if (a == 2) v[NCH-1:0] = m_xfer;
        else if (a == 3) v[2:0] = {|m_xfer, |m_ovf, |m_irq};
        else if (a >= 32 && a < 32 + NCH)
            v[2:0] = {m_xfer[a-32], m_ovf[a-32], m_irq[a-32]};
        return v;
    endfunction

    task automatic chk_ports();
        chk("R8 ch_irq",  32'(ch_irq),  32'(m_irq));
        chk("R3 ch_ovf",  32'(ch_ovf),  32'(m_ovf));
        chk("R6 ch_xfer", 32'(ch_xfer), 32'(m_xfer));
        chk("R11 irq_any", 32'(irq_any), 32'(|m_irq));
    endtask

    task automatic step(input logic [NCH-1:0] si, input logic [NCH-1:0] sx,
                        input logic w, input int a, input logic [31:0] d);
        logic [NCH-1:0] ci, co, cx;
        ci = '0; co = '0; cx = '0;
        @(negedge clk);
        irq_evt = si; xfer_evt = sx; wr = w; addr = 6'(a); wdata = d;
        if (w) begin
            if (a == 0) ci = d[NCH-1:0];
            else if (a == 1) co = d[NCH-1:0];
            else if (a == 2) cx = d[NCH-1:0];
            else if (a >= 32 && a < 32 + NCH) begin
                ci[a-32] = d[0]; co[a-32] = d[1]; cx[a-32] = d[2];
            end
        end
        @(negedge clk);
        irq_evt = '0; xfer_evt = '0; wr = 1'b0;
        m_ovf  = (si & m_irq) | (m_ovf & ~co);
        m_irq  = si | (m_irq & ~ci);
        m_xfer = sx | (m_xfer & ~cx);
        chk_ports();
    endtask

    task automatic rd(input string req, input int a);
        @(negedge clk);
        addr = 6'(a); wr = 1'b0;
        @(negedge clk);
        chk(req, rdata, exp_rd(a));
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk_ports();
        chk("R1 rdata", rdata, 32'h0);
        rd("R1 irq word", 0);
        rd("R1 ovf word", 1);
        rd("R1 xfer word", 2);
        rd("R1 summary", 3);
        rd("R1 chan view", 32);

        for (int c = 0; c < NCH; c++) begin
            logic [NCH-1:0] m;
            m = NCH'(1) << c;
            step(m, '0, 1'b0, 0, 0);              // R2 first interrupt, R4 no overflow
            rd("R2 irq word", 0);
            rd("R4 no ovf on first", 1);
            step(m, '0, 1'b0, 0, 0);              // R3 overflow
            rd("R3 ovf word", 1);
            rd("R8 chan view", 32 + c);
            rd("R12 summary", 3);
            step('0, '0, 1'b1, 0, 32'(m));        // R4 clear irq keeps ovf
            rd("R4 ovf kept", 1);
            step('0, '0, 1'b1, 1, 32'h0);         // R5 zero write
            rd("R5 zero write", 1);
            step('0, '0, 1'b1, 1, 32'(m));        // R5 clear ovf
            rd("R5 ovf cleared", 1);
            step('0, m, 1'b0, 0, 0);              // R6
            rd("R6 xfer word", 2);
            step(m, m, 1'b1, 2, 32'hFFFF_FFFF);   // R7 xfer set beats clear
            rd("R7 xfer set wins", 2);
            step(m, '0, 1'b1, 0, 32'(m));         // R7 irq set beats clear, R3 ovf
            rd("R7 irq set wins", 0);
            step('0, '0, 1'b1, 3, 32'hFFFF_FFFF); // R10 read-only
            step('0, '0, 1'b1, 40 + c, 32'hFFFF_FFFF); // R10 unmapped
            rd("R10 no change", 32 + c);
            rd("R9 unmapped reads 0", 50);
            step('0, '0, 1'b1, 32 + c, 32'h7);    // R8 per-channel clear
            rd("R8 grouped after chan clear", 0);
            rd("R8 ovf after chan clear", 1);
            rd("R8 xfer after chan clear", 2);
        end

        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            int a;
            logic [31:0] d;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0: a = 0;
                3'd1: a = 1;
                3'd2: a = 2;
                3'd3: a = 3;
                3'd4, 3'd5: a = 32 + int'(lf[7:5]) % NCH;
                3'd6: a = 40 + int'(lf[7:5]);
                default: a = 63;
            endcase
            d = {lf, lf ^ 16'h5A5A};
            step(NCH'(lf[15:8]) & NCH'(lf[11:4]), NCH'(lf[13:6]) & NCH'(lf[9:2]),
                 lf[3], a, d);
            rd("R9 random read", int'(lf[4:0]) < 4 ? int'(lf[1:0]) : 32 + int'(lf[12:10]) % 12);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule